// File: doc/BRIEF.md
# Timecode Continuity Error Counter

This block sits behind a timecode decoder. Each decoded value arrives as one beat on a valid/ready stream, as eight packed BCD digits (hours, minutes, seconds, frames). The block tests the value for plausibility at the active frame rate. It also tests whether the value follows on from the last plausible value it saw. Every beat that fails either test adds one to an 8-bit saturating error count. Plausible beats pass through to a one-stage output register. Implausible beats are dropped.

The continuity rule depends on the source. A linear code may step one frame up or one frame down, so forward and reverse play are both continuous. A video-field code must step one frame up on a first field. On a second field it must repeat the value just received.

A host port reads the count in one of several modes. One mode leaves the count unchanged. One clears it after the read. A third clears it and also exempts the next beat from the continuity test. This lets a fresh measurement start without a false error.

Input back-pressure follows one rule: `in_ready` is high whenever the output register is empty or is being drained in the same cycle. A beat is accepted on a rising edge where `in_valid` and `in_ready` are both high. The output beat is held unchanged while `out_valid` is high and `out_ready` is low.

Top module: `tc_err_counter`

## Requirements
- R1: A beat is implausible if any of the following holds: a BCD digit is above 9; hours ≥ 24; minutes ≥ 60; seconds ≥ 60; frames ≥ the frame rate. The `rate` encoding is 0 = 24, 1 = 25, 2 = 30 and 3 = 30 drop-frame. An implausible beat adds exactly one error, produces no output beat and does not become the reference.
- R2: At `rate` = 3, frame numbers 00 and 01 are implausible at second 00 of every minute that is not a multiple of ten. The one-frame step in either direction skips them.
- R3: With `in_vid` = 0, a plausible beat is continuous only if it is exactly one frame above or one frame below the reference (the last plausible beat). The step wraps through 23:59:59 and the last frame. A discontinuous beat adds one error and still becomes the reference.
- R4: With `in_vid` = 1, a beat with `in_fld2` = 0 must be one frame above the reference. A beat with `in_fld2` = 1 must equal the reference. Otherwise it adds one error.
- R5: The count saturates at 255. Further errors leave it at 255.
- R6: A read with `rd_mode` 1 or 3 returns the count and leaves it unchanged.
- R7: A read with `rd_mode` 2 returns the count and clears it. The next beat is still checked for continuity.
- R8: A read with `rd_mode` 0 returns the count and clears it. The next accepted beat is exempt from the continuity test but is still tested for plausibility.
- R9: `rd_data` carries the count from before the cycle of the request and is flagged by `rd_valid` one cycle after `rd_req`. An error in the same cycle as a clearing read leaves the count at 1. An error in the same cycle as a plain read is added.
- R10: After reset, the count is 0, `out_valid` and `rd_valid` are low, and the first beat is not tested for continuity.
- R11: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. A stalled output beat keeps `out_valid` high and `out_tc` unchanged, and no beat is accepted while stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate | input | 2 | Frame rate: 0 = 24, 1 = 25, 2 = 30, 3 = 30 drop-frame |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat may be accepted |
| in_tc | input | 32 | BCD timecode {hh, mm, ss, ff} |
| in_vid | input | 1 | 1 = video-field source, 0 = linear source |
| in_fld2 | input | 1 | 1 = second field (video source only) |
| out_valid | output | 1 | Plausible beat available |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_tc | output | 32 | Forwarded plausible timecode |
| rd_req | input | 1 | Host read request, one cycle |
| rd_mode | input | 2 | 0 = read, clear, skip next check; 1 or 3 = read only; 2 = read and clear |
| rd_valid | output | 1 | `rd_data` is valid |
| rd_data | output | 8 | Count returned by the read |
| err_count | output | 8 | Current error count |

## Verification
A beat accepted on rising edge k shows up in `err_count` and on the output register right after that edge. A read requested at edge k returns its data, with `rd_valid` high, right after edge k. Nothing waits an extra cycle. The bench's reference model therefore updates on each rising edge from the inputs held there, and every output is compared on the following falling edge. Stimulus changes two nanoseconds after a rising edge, so no comparison sees a half-applied input.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  localparam int TC_W = 32;

  typedef enum logic [1:0] {
    RATE_24   = 2'd0,
    RATE_25   = 2'd1,
    RATE_30   = 2'd2,
    RATE_30DF = 2'd3
  } rate_e;

  typedef enum logic [1:0] {
    RD_CLR_SKIP = 2'd0,
    RD_PEEK     = 2'd1,
    RD_CLR      = 2'd2,
    RD_PEEK_ALT = 2'd3
  } rdmode_e;

  function automatic int fps_of(rate_e r);
    case (r)
      RATE_24: return 24;
      RATE_25: return 25;
      default: return 30;
    endcase
  endfunction

  function automatic int bcd2i(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] i2bcd(int v);
    logic [7:0] r;
    r[7:4] = 4'(v / 10);
    r[3:0] = 4'(v % 10);
    return r;
  endfunction

  // One-frame step up (down = 0) or down (down = 1), drop-frame aware.
  function automatic logic [TC_W-1:0] tc_step(logic [TC_W-1:0] t, rate_e r, logic down);
    int h, m, s, f, n;
    logic df;
    h  = bcd2i(t[31:24]);
    m  = bcd2i(t[23:16]);
    s  = bcd2i(t[15:8]);
    f  = bcd2i(t[7:0]);
    n  = fps_of(r);
    df = (r == RATE_30DF);
    if (!down) begin
      f = f + 1;
      if (f >= n) begin
        f = 0;
        s = s + 1;
        if (s >= 60) begin
          s = 0;
          m = m + 1;
          if (m >= 60) begin
            m = 0;
            h = (h >= 23) ? 0 : h + 1;
          end
        end
      end
      if (df && s == 0 && f < 2 && (m % 10) != 0) f = 2;
    end else begin
      if (df && s == 0 && f == 2 && (m % 10) != 0) f = 0;
      if (f == 0) begin
        f = n - 1;
        if (s == 0) begin
          s = 59;
          if (m == 0) begin
            m = 59;
            h = (h == 0) ? 23 : h - 1;
          end else m = m - 1;
        end else s = s - 1;
      end else f = f - 1;
    end
    return {i2bcd(h), i2bcd(m), i2bcd(s), i2bcd(f)};
  endfunction
endpackage

// File: rtl/tcc_plaus.sv
module tcc_plaus
  import tcc_pkg::*;
(
  input  logic [TC_W-1:0] tc,
  input  rate_e           rate,
  output logic            ok
);
  localparam int NIB = TC_W / 4;

  logic [NIB-1:0] dig_ok;
  genvar gi;
  generate
    for (gi = 0; gi < NIB; gi++) begin : g_dig
      assign dig_ok[gi] = (tc[4*gi +: 4] <= 4'd9);
    end
  endgenerate

  int hh, mm, ss, ff;
  logic range_ok, drop_hole;

  always_comb begin
    hh        = bcd2i(tc[31:24]);
    mm        = bcd2i(tc[23:16]);
    ss        = bcd2i(tc[15:8]);
    ff        = bcd2i(tc[7:0]);
    range_ok  = (hh < 24) && (mm < 60) && (ss < 60) && (ff < fps_of(rate));
    drop_hole = (rate == RATE_30DF) && (ss == 0) && (ff < 2) && ((mm % 10) != 0);
    ok        = (&dig_ok) && range_ok && !drop_hole;
  end
endmodule

// File: rtl/tcc_seq.sv
module tcc_seq
  import tcc_pkg::*;
(
  input  logic [TC_W-1:0] tc,
  input  logic [TC_W-1:0] ref_tc,
  input  rate_e           rate,
  input  logic            vid,
  input  logic            fld2,
  output logic            ok
);
  logic [TC_W-1:0] up_tc, dn_tc;

  always_comb begin
    up_tc = tc_step(ref_tc, rate, 1'b0);
    dn_tc = tc_step(ref_tc, rate, 1'b1);
    if (vid) ok = fld2 ? (tc == ref_tc) : (tc == up_tc);
    else     ok = (tc == up_tc) || (tc == dn_tc);
  end
endmodule

// File: rtl/tcc_errcnt.sv
module tcc_errcnt
  import tcc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bump,
  input  logic             rd_req,
  input  rdmode_e          rd_mode,
  output logic [CNT_W-1:0] count,
  output logic             rd_valid,
  output logic [CNT_W-1:0] rd_data,
  output logic             arm_skip
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             clr;
  logic [CNT_W-1:0] base, nxt;

  always_comb begin
    clr      = rd_req && (rd_mode == RD_CLR_SKIP || rd_mode == RD_CLR);
    arm_skip = rd_req && (rd_mode == RD_CLR_SKIP);
    base     = clr ? '0 : count;
    nxt      = (bump && base != CNT_MAX) ? base + 1'b1 : base;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count    <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      count    <= nxt;
      rd_valid <= rd_req;
      if (rd_req) rd_data <= count;
    end
  end
endmodule

// File: rtl/tc_err_counter.sv
module tc_err_counter
  import tcc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       rate,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [TC_W-1:0]  in_tc,
  input  logic             in_vid,
  input  logic             in_fld2,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [TC_W-1:0]  out_tc,
  input  logic             rd_req,
  input  logic [1:0]       rd_mode,
  output logic             rd_valid,
  output logic [CNT_W-1:0] rd_data,
  output logic [CNT_W-1:0] err_count
);
  rate_e           rate_q;
  logic            accept, plaus, seq_ok, bump, arm_skip;
  logic            has_ref, skip_next;
  logic [TC_W-1:0] ref_tc;

  assign rate_q   = rate_e'(rate);
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign bump     = accept && (!plaus || (has_ref && !skip_next && !seq_ok));

  tcc_plaus u_plaus (
    .tc   (in_tc),
    .rate (rate_q),
    .ok   (plaus)
  );

  tcc_seq u_seq (
    .tc     (in_tc),
    .ref_tc (ref_tc),
    .rate   (rate_q),
    .vid    (in_vid),
    .fld2   (in_fld2),
    .ok     (seq_ok)
  );

  tcc_errcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .bump     (bump),
    .rd_req   (rd_req),
    .rd_mode  (rdmode_e'(rd_mode)),
    .count    (err_count),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .arm_skip (arm_skip)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      has_ref   <= 1'b0;
      ref_tc    <= '0;
      skip_next <= 1'b0;
      out_valid <= 1'b0;
      out_tc    <= '0;
    end else begin
      if (arm_skip)    skip_next <= 1'b1;
      else if (accept) skip_next <= 1'b0;
      if (accept && plaus) begin
        has_ref   <= 1'b1;
        ref_tc    <= in_tc;
        out_valid <= 1'b1;
        out_tc    <= in_tc;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tc_err_counter_chk.sv
module tc_err_counter_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [31:0]      out_tc,
  input logic             rd_req,
  input logic [1:0]       rd_mode,
  input logic             rd_valid,
  input logic [CNT_W-1:0] rd_data,
  input logic [CNT_W-1:0] err_count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (err_count == CNT_MAX && !rd_req) |=> err_count == CNT_MAX); // R5
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n) !rd_req |=> (err_count == $past(err_count) || err_count == $past(err_count) + 1'b1)); // R1
  AST_CLEAR_LOW: assert property (@(posedge clk) disable iff (!rst_n) (rd_req && (rd_mode == 2'd0 || rd_mode == 2'd2)) |=> err_count <= 1); // R7
  AST_READ_DATA: assert property (@(posedge clk) disable iff (!rst_n) rd_req |=> (rd_valid && rd_data == $past(err_count))); // R9
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (!in_valid && !rd_req) |=> $stable(err_count)); // R6
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_ready) |=> (out_valid && $stable(out_tc))); // R11
  AST_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && !in_ready && !rd_req) |=> $stable(err_count)); // R11
endmodule

bind tc_err_counter tc_err_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_tc    (out_tc),
  .rd_req    (rd_req),
  .rd_mode   (rd_mode),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data),
  .err_count (err_count)
);

// File: tb/tc_err_counter_test.sv
`timescale 1ns/1ps
module tc_err_counter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  rate = 2'd1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_tc = '0;
  logic        in_vid = 1'b0;
  logic        in_fld2 = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_tc;
  logic        rd_req = 1'b0;
  logic [1:0]  rd_mode = 2'd1;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic [7:0]  err_count;

  int    tests = 0, fails = 0;
  bit    done = 0;
  string cur_req = "R10";

  always #10 clk = ~clk;

  tc_err_counter uut (
    .clk(clk), .rst_n(rst_n), .rate(rate), .in_valid(in_valid), .in_ready(in_ready),
    .in_tc(in_tc), .in_vid(in_vid), .in_fld2(in_fld2), .out_valid(out_valid),
    .out_ready(out_ready), .out_tc(out_tc), .rd_req(rd_req), .rd_mode(rd_mode),
    .rd_valid(rd_valid), .rd_data(rd_data), .err_count(err_count)
  );

  // ---------------- reference model ----------------
  function automatic int dec2(bit [7:0] b);
    return b[7:4] * 10 + b[3:0];
  endfunction

  function automatic int m_fps(int r);
    return (r == 0) ? 24 : (r == 1) ? 25 : 30;
  endfunction

  function automatic bit m_plaus(bit [31:0] t, int r);
    int h, m, s, f;
    for (int i = 0; i < 8; i++) if (t[4*i +: 4] > 9) return 0;
    h = dec2(t[31:24]); m = dec2(t[23:16]); s = dec2(t[15:8]); f = dec2(t[7:0]);
    if (h > 23 || m > 59 || s > 59 || f >= m_fps(r)) return 0;
    if (r == 3 && s == 0 && f < 2 && (m % 10) != 0) return 0;
    return 1;
  endfunction

  function automatic int m_idx(bit [31:0] t, int r);
    int tm, raw;
    tm  = dec2(t[31:24]) * 60 + dec2(t[23:16]);
    raw = (tm * 60 + dec2(t[15:8])) * m_fps(r) + dec2(t[7:0]);
    if (r == 3) raw = raw - 2 * (tm - tm / 10);
    return raw;
  endfunction

  function automatic int m_day(int r);
    return (r == 3) ? 2589408 : 86400 * m_fps(r);
  endfunction

  int        m_cnt;
  bit        m_has_ref, m_skip, m_ov, m_rdv, m_acc;
  bit [31:0] m_ref, m_otc;
  int        m_rdd;

  always @(posedge clk) begin
    bit p, e;
    int d, base;
    if (!rst_n) begin
      m_cnt = 0; m_has_ref = 0; m_skip = 0; m_ov = 0; m_rdv = 0; m_rdd = 0; m_acc = 0;
    end else begin
      m_acc = in_valid && (!m_ov || out_ready);
      p = m_plaus(in_tc, rate);
      e = 0;
      if (m_acc) begin
        if (!p) e = 1;
        else if (m_has_ref && !m_skip) begin
          d = (m_idx(in_tc, rate) - m_idx(m_ref, rate) + m_day(rate)) % m_day(rate);
          if (in_vid) e = in_fld2 ? (d != 0) : (d != 1);
          else        e = !(d == 1 || d == m_day(rate) - 1);
        end
      end
      m_rdv = rd_req;
      if (rd_req) m_rdd = m_cnt;
      base = (rd_req && (rd_mode == 0 || rd_mode == 2)) ? 0 : m_cnt;
      if (e && base < 255) base++;
      m_cnt = base;
      if (rd_req && rd_mode == 0) m_skip = 1;
      else if (m_acc) m_skip = 0;
      if (m_acc && p) begin
        m_ov = 1; m_otc = in_tc; m_ref = in_tc; m_has_ref = 1;
      end else if (out_ready) m_ov = 0;
    end
  end

  // every-cycle comparison at the falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit bad;
      bad = (err_count !== 8'(m_cnt)) || (out_valid !== m_ov) || (rd_valid !== m_rdv) ||
            (in_ready !== (!m_ov || out_ready)) ||
            (m_ov && out_tc !== m_otc) || (m_rdv && rd_data !== 8'(m_rdd));
      tests++;
      if (bad) begin
        fails++;
        $display("FAIL %s cycle compare: act cnt=%0d ov=%0b tc=%h rdv=%0b rd=%0d rdy=%0b exp cnt=%0d ov=%0b tc=%h rdv=%0b rd=%0d",
                 cur_req, err_count, out_valid, out_tc, rd_valid, rd_data, in_ready,
                 m_cnt, m_ov, m_otc, m_rdv, m_rdd);
      end
    end
  end

  // ---------------- helpers ----------------
  function automatic bit [31:0] T(int h, int m, int s, int f);
    return {4'(h / 10), 4'(h % 10), 4'(m / 10), 4'(m % 10),
            4'(s / 10), 4'(s % 10), 4'(f / 10), 4'(f % 10)};
  endfunction

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(bit [31:0] t, bit vid = 0, bit f2 = 0);
    in_valid = 1; in_tc = t; in_vid = vid; in_fld2 = f2;
    do begin @(posedge clk); #2; end while (!m_acc);
    in_valid = 0;
  endtask

  task automatic rd(int mode, output int v);
    rd_req = 1; rd_mode = 2'(mode);
    @(posedge clk); #2;
    rd_req = 0;
    v = rd_data;
  endtask

  task automatic send_rd(bit [31:0] t, int mode, output int v);
    in_valid = 1; in_tc = t; rd_req = 1; rd_mode = 2'(mode);
    @(posedge clk); #2;
    in_valid = 0; rd_req = 0;
    v = rd_data;
  endtask

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  // ---------------- stimulus ----------------
  initial begin
    int v;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    #1;
    cur_req = "R10";
    chk("R10 count after reset", err_count, 0);
    chk("R10 out_valid after reset", out_valid, 0);
    chk("R10 rd_valid after reset", rd_valid, 0);
    idle(1);

    // linear, 25 fps, forward across a minute, then reverse
    cur_req = "R3"; rate = 2'd1;
    for (int f = 20; f < 25; f++) send(T(0, 0, 59, f));
    for (int f = 0; f < 5; f++) send(T(0, 1, 0, f));
    send(T(0, 1, 0, 3)); send(T(0, 1, 0, 2));
    rd(1, v); chk("R3 forward/reverse no errors", v, 0);
    send(T(0, 1, 0, 10));
    rd(1, v); chk("R3 jump counts one", v, 1);
    send(T(23, 59, 59, 24)); send(T(0, 0, 0, 0));
    rd(1, v); chk("R3 day wrap is continuous", v, 2);

    // implausible beats
    cur_req = "R1";
    send(T(0, 0, 0, 25));
    chk("R1 implausible not forwarded", out_valid, 0);
    send(32'h0000_0A01);
    send(T(24, 0, 0, 0));
    send(T(0, 0, 0, 1));
    cur_req = "R7";
    rd(2, v); chk("R1 R7 three implausible counted once each", v, 5);
    rd(1, v); chk("R7 cleared", v, 0);
    send(T(0, 0, 5, 0));
    rd(1, v); chk("R7 next beat still checked", v, 1);

    cur_req = "R8";
    rd(0, v); chk("R8 read returns count", v, 1);
    send(T(12, 0, 0, 0)); send(T(12, 0, 0, 1));
    rd(1, v); chk("R8 first beat after clear exempt", v, 0);
    send(T(12, 0, 0, 5));
    rd(1, v); chk("R8 checking resumes", v, 1);

    // drop-frame
    cur_req = "R2"; rate = 2'd3;
    rd(0, v);
    send(T(0, 0, 59, 29)); send(T(0, 1, 0, 2));
    send(T(0, 1, 0, 1)); send(T(0, 0, 59, 29));
    rd(1, v); chk("R2 skip up/down, hole implausible", v, 1);
    rd(0, v);
    send(T(0, 9, 59, 29)); send(T(0, 10, 0, 0)); send(T(0, 10, 0, 1));
    rd(1, v); chk("R2 tenth minute keeps frames 00 01", v, 0);

    // video fields, 30 fps
    cur_req = "R4"; rate = 2'd2;
    rd(0, v);
    send(T(1, 0, 0, 0), 1, 0); send(T(1, 0, 0, 0), 1, 1);
    send(T(1, 0, 0, 1), 1, 0); send(T(1, 0, 0, 1), 1, 1);
    send(T(1, 0, 0, 2), 1, 0); send(T(1, 0, 0, 3), 1, 1);
    send(T(1, 0, 0, 4), 1, 0); send(T(1, 0, 0, 6), 1, 0);
    rd(1, v); chk("R4 field rules", v, 2);

    // saturation
    cur_req = "R5";
    rd(0, v);
    for (int i = 0; i < 260; i++) send(32'hFFFF_FFFF);
    rd(1, v); chk("R5 saturates", v, 255);
    send_rd(32'hFFFF_FFFF, 1, v); chk("R5 read at max", v, 255);
    rd(1, v); chk("R5 stays at max", v, 255);

    // coincident error and read
    cur_req = "R9";
    send_rd(32'hFFFF_FFFF, 2, v); chk("R9 read returns pre value", v, 255);
    rd(1, v); chk("R9 clear plus error gives one", v, 1);
    send_rd(32'hFFFF_FFFF, 1, v); chk("R9 peek returns pre value", v, 1);
    rd(1, v); chk("R9 peek plus error adds", v, 2);
    send_rd(32'hFFFF_FFFF, 0, v);
    rd(3, v); chk("R6 R9 clear-skip plus error gives one", v, 1);
    cur_req = "R6";
    rd(3, v); chk("R6 mode 3 leaves count", v, 1);

    // back-pressure
    cur_req = "R11"; rate = 2'd1; out_ready = 0;
    send(T(0, 0, 0, 0));
    in_valid = 1; in_tc = T(0, 0, 0, 1); in_vid = 0;
    idle(3);
    chk("R11 in_ready low while stalled", in_ready, 0);
    chk("R11 out_tc held", int'(out_tc), int'(T(0, 0, 0, 0)));
    out_ready = 1;
    do begin @(posedge clk); #2; end while (!m_acc);
    in_valid = 0;
    chk("R11 next beat delivered", int'(out_tc), int'(T(0, 0, 0, 1)));

    // reset mid-run
    cur_req = "R10";
    rst_n = 0; idle(2); rst_n = 1;
    send(T(5, 5, 5, 5));
    rd(1, v); chk("R10 first beat after reset unchecked", v, 0);

    idle(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(64'd20 * 150000);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule